// File: doc/BRIEF.md
# Two-Wire Register Slave with Strap-Selected Address

This block is a two-wire (I2C) target that gives a bus master read and write access to a small bank of 8-bit configuration registers. It oversamples the serial clock and data lines with the system clock. It finds START and STOP conditions and collects bytes MSB first. It answers a 7-bit device address whose six upper bits are fixed and whose lowest bit follows the level of a strap pin. It acknowledges by pulling the data line low through an output enable. Every register is also presented in parallel on `cfg_o`, so that neighbouring logic can use the settings.

A write transfer carries a pointer byte and then any number of data bytes. The pointer byte holds a register index and an auto-advance flag. A read transfer returns bytes starting at the current pointer. The same strap pin doubles as the chip select of an alternative serial port. The first falling edge seen on it after reset latches that alternative mode. From then on this slave stays silent on the bus until the next reset.

The byte stream travels on the two-wire bus, which has its own acknowledge handshake. The block therefore has no valid/ready interface and never holds the clock low. The master sets the pace, and the slave answers within a few system clocks of each SCL edge.

Top module: `i2cs_strap_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {6'b001000, level of strap_i}. It acknowledges by raising sda_oe_o through the 9th SCL clock. Any other address gets no acknowledge and changes no register.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Either one aborts a partial byte, so an interrupted byte writes nothing. A repeated START begins a new address phase and keeps the pointer.
- R3: In a write, the byte after the address is the pointer byte. Bit 7 is the auto-advance flag and bits 6:0 are the register index. The slave acknowledges it.
- R4: Each further byte of a write is acknowledged and stored in the register the pointer selects. Register k appears on cfg_o[8k+7:8k].
- R5: With the auto-advance flag set to 1, the pointer steps by one (modulo 128) after every data byte written or read. With the flag at 0 it stays on the same register.
- R6: In a read (address bit 0 = 1), the register at the current pointer is shifted out MSB first, starting right after the address acknowledge. Further bytes follow each master acknowledge.
- R7: A master NACK after a read byte ends the transfer, and the slave leaves SDA released.
- R8: sda_oe_o changes only while SCL is low.
- R9: The first high-to-low transition of strap_i after reset sets spi_sel_o. It stays set until reset, and from then on the slave neither acknowledges nor writes.
- R10: After reset all registers are 0x00, sda_oe_o and spi_sel_o are 0, and the pointer is 0 with auto-advance off.
- R11: Pointer values at or above NUM_REGS read back as 0x00, and writes to them are dropped. They are still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_i | input | 1 | Address LSB strap, also the alternative port's chip select |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| spi_sel_o | output | 1 | Latched flag: the alternative serial port has been selected |
| cfg_o | output | NUM_REGS*8 | All registers side by side, register k in bits 8k+7:8k |

## Verification
Every bus input passes through a two-stage synchroniser and one edge register. The slave therefore reacts about four system clocks after an SCL edge: it drives or releases SDA, or updates a register. A register write becomes visible on cfg_o about four clocks after the SCL rise that carries bit 0 of the data byte. The latch reaches spi_sel_o three clocks after strap_i falls. The bench keeps each SCL phase at least eight clocks long. It samples acknowledges and read bits at the midpoint of SCL high, and checks cfg_o and spi_sel_o only after a STOP or a wait of several clocks. No check lands inside the reaction window.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } i2cs_state_e;

  localparam int PTR_W = 7;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/i2cs_mode_latch.sv
module i2cs_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_q,
  output logic spi_mode
);

  logic strap_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_prev <= 1'b0;
      spi_mode   <= 1'b0;
    end else begin
      strap_prev <= strap_q;
      if (strap_prev && !strap_q) spi_mode <= 1'b1;
    end
  end

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int NUM_REGS = 8,
  parameter int AW       = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [7:0]            wdata,
  input  logic [AW-1:0]         raddr,
  output logic [7:0]            rdata,
  output logic [NUM_REGS*8-1:0] flat
);

  logic [7:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[g] <= 8'h00;
      else if (we && (waddr == AW'(g)))    mem[g] <= wdata;
    end
    assign flat[g*8 +: 8] = mem[g];
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (raddr == AW'(i)) rdata = mem[i];
    end
  end

endmodule

// File: rtl/i2cs_strap_slave.sv
module i2cs_strap_slave #(
  parameter int         NUM_REGS    = 8,
  parameter logic [5:0] ADDR_HI     = 6'b001000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  strap_i,
  output logic                  sda_oe_o,
  output logic                  spi_sel_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  import i2cs_pkg::*;

  localparam int AW = PTR_W;

  // synchronised bus lines: {strap, sda, scl}
  logic [2:0] sync_q;
  logic       scl_q, sda_q, strap_q;
  logic       scl_d, sda_d;

  i2cs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({strap_i, sda_i, scl_i}),
    .q     (sync_q)
  );

  assign {strap_q, sda_q, scl_q} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  =  scl_q & ~scl_d;
  assign scl_fall  = ~scl_q &  scl_d;
  assign start_det =  scl_q &  scl_d &  sda_d & ~sda_q;
  assign stop_det  =  scl_q &  scl_d & ~sda_d &  sda_q;

  logic spi_mode;

  i2cs_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_q  (strap_q),
    .spi_mode (spi_mode)
  );

  // byte engine state
  i2cs_state_e   state;
  logic [3:0]    cnt;
  logic [7:0]    shift;
  logic [7:0]    tx_sh;
  logic [AW-1:0] ptr;
  logic          inc;
  logic          oe;
  logic          ack_on;
  logic          rw;
  logic          mack;

  logic [7:0] rx_byte;
  logic [7:0] rd_data;
  logic       wr_en;
  logic       last_bit;

  assign rx_byte  = {shift[6:0], sda_q};
  assign last_bit = (cnt == 4'd7);
  assign wr_en    = !spi_mode && (state == ST_WR) && scl_rise && last_bit;

  i2cs_regfile #(.NUM_REGS(NUM_REGS), .AW(AW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (ptr),
    .wdata (rx_byte),
    .raddr (ptr),
    .rdata (rd_data),
    .flat  (cfg_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= 4'd0;
      shift  <= 8'h00;
      tx_sh  <= 8'h00;
      ptr    <= '0;
      inc    <= 1'b0;
      oe     <= 1'b0;
      ack_on <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
    end else if (spi_mode) begin
      state  <= ST_IDLE;
      oe     <= 1'b0;
      ack_on <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= 4'd0;
      oe     <= 1'b0;
      ack_on <= 1'b0;
      mack   <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      oe     <= 1'b0;
      ack_on <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (scl_rise) begin
            shift <= rx_byte;
            cnt   <= cnt + 4'd1;
            if (last_bit) begin
              cnt <= 4'd0;
              if (state == ST_ADDR) begin
                if (rx_byte[7:1] == {ADDR_HI, strap_q}) begin
                  rw    <= rx_byte[0];
                  state <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                ptr   <= rx_byte[AW-1:0];
                inc   <= rx_byte[7];
                state <= ST_PTR_ACK;
              end else begin
                if (inc) ptr <= ptr + AW'(1);
                state <= ST_WR_ACK;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            if (!ack_on) begin
              oe     <= 1'b1;
              ack_on <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              cnt    <= 4'd0;
              oe     <= 1'b0;
              if (state == ST_ADDR_ACK) begin
                if (rw) begin
                  oe    <= ~rd_data[7];
                  tx_sh <= {rd_data[6:0], 1'b0};
                  cnt   <= 4'd1;
                  state <= ST_RD;
                end else begin
                  state <= ST_PTR;
                end
              end else begin
                state <= ST_WR;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe    <= 1'b0;
              cnt   <= 4'd0;
              mack  <= 1'b0;
              if (inc) ptr <= ptr + AW'(1);
              state <= ST_RD_ACK;
            end else begin
              oe    <= ~tx_sh[7];
              tx_sh <= {tx_sh[6:0], 1'b0};
              cnt   <= cnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            if (sda_q) state <= ST_IDLE;
            else       mack  <= 1'b1;
          end else if (scl_fall && mack) begin
            mack  <= 1'b0;
            oe    <= ~rd_data[7];
            tx_sh <= {rd_data[6:0], 1'b0};
            cnt   <= 4'd1;
            state <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o  = oe;
  assign spi_sel_o = spi_mode;

endmodule

// File: rtl/i2cs_strap_slave_chk.sv
module i2cs_strap_slave_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_q,
  input logic         scl_d,
  input logic         stop_det,
  input logic         spi_mode,
  input logic         sda_oe,
  input logic [W-1:0] cfg
);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(spi_mode) |-> !$past(scl_q)); // R8

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !sda_oe); // R2

  AST_SPI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_mode) |-> spi_mode); // R9

  AST_SPI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_mode) |-> !sda_oe); // R9

  AST_CFG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> ($past(scl_q) && !$past(scl_d) && !$past(spi_mode))); // R4

endmodule

bind i2cs_strap_slave i2cs_strap_slave_chk #(.W(NUM_REGS*8)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_q    (scl_q),
  .scl_d    (scl_d),
  .stop_det (stop_det),
  .spi_mode (spi_mode),
  .sda_oe   (sda_oe_o),
  .cfg      (cfg_o)
);

// File: tb/i2cs_strap_slave_tb_top.sv
module i2cs_strap_slave_tb_top;

  localparam int NR = 8;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_oe, spi_sel;
  logic [NR*8-1:0] cfg;
  wire  sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2cs_strap_slave #(.NUM_REGS(NR)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .strap_i   (strap),
    .sda_oe_o  (sda_oe),
    .spi_sel_o (spi_sel),
    .cfg_o     (cfg)
  );

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;

  logic [7:0] mdl [NR];
  logic [6:0] mptr = '0;
  logic       minc = 1'b0;
  logic [7:0] wbuf [4];

  // R8 monitor: the output enable may only move while SCL is low
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) oe_viol++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] mdl_flat();
    logic [NR*8-1:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [6:0] p);
    return (int'(p) < NR) ? mdl[p[2:0]] : 8'h00;
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    hold(Q);
    scl_m = 1'b1; hold(2*Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    b = sda_line; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  // write transfer: address, pointer byte, n data bytes from wbuf
  task automatic wr_txn(input logic [6:0] dev, input logic [7:0] pb, input int n, input logic exp_ack);
    logic a;
    bus_start();
    write_byte({dev, 1'b0}, a);
    chk(a == exp_ack, "R1 address acknowledge", 64'(a), 64'(exp_ack));
    if (a) begin
      write_byte(pb, a);
      chk(a, "R3 pointer byte acknowledge", 64'(a), 64'd1);
      mptr = pb[6:0];
      minc = pb[7];
      for (int i = 0; i < n; i++) begin
        write_byte(wbuf[i], a);
        chk(a, "R4 data byte acknowledge", 64'(a), 64'd1);
        if (int'(mptr) < NR) mdl[mptr[2:0]] = wbuf[i];
        if (minc) mptr = mptr + 7'd1;
      end
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [6:0] dev, input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    write_byte({dev, 1'b1}, a);
    chk(a, "R6 read address acknowledge", 64'(a), 64'd1);
    for (int i = 0; i < n; i++) begin
      read_byte(d, i < n - 1);
      chk(d == exp_rd(mptr), "R6 R5 read data", 64'(d), 64'(exp_rd(mptr)));
      if (minc) mptr = mptr + 7'd1;
    end
    hold(2);
    chk(sda_oe == 1'b0, "R7 line released after NACK", 64'(sda_oe), 64'd0);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    logic [7:0] pb;
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;

    hold(5);
    rst_n = 1'b1;
    hold(10);
    // R10 reset state
    chk(cfg == '0, "R10 registers cleared", 64'(cfg), 64'd0);
    chk(sda_oe == 1'b0, "R10 line released", 64'(sda_oe), 64'd0);
    chk(spi_sel == 1'b0, "R10 mode flag clear", 64'(spi_sel), 64'd0);

    // R1: strap low, so 0x11 is foreign
    wbuf[0] = 8'h3C;
    wr_txn(7'h11, 8'h02, 1, 1'b0);
    chk(cfg == mdl_flat(), "R1 foreign address writes nothing", 64'(cfg), 64'(mdl_flat()));

    // R1 R3 R4: strap low matches 0x10
    wbuf[0] = 8'hA5;
    wr_txn(7'h10, 8'h02, 1, 1'b1);
    chk(cfg == mdl_flat(), "R4 register written", 64'(cfg), 64'(mdl_flat()));

    // raise the strap: rising edge does not latch the mode (R9)
    strap = 1'b1;
    hold(10);
    chk(spi_sel == 1'b0, "R9 rising strap keeps two-wire mode", 64'(spi_sel), 64'd0);

    // R5 auto-advance on writes
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_txn(7'h11, 8'h84, 3, 1'b1);
    chk(cfg == mdl_flat(), "R5 burst with auto-advance", 64'(cfg), 64'(mdl_flat()));

    // R5 fixed pointer
    wbuf[0] = 8'h44; wbuf[1] = 8'h55;
    wr_txn(7'h11, 8'h01, 2, 1'b1);
    chk(cfg == mdl_flat(), "R5 fixed pointer overwrites", 64'(cfg), 64'(mdl_flat()));

    // R2 repeated start: set pointer then read without STOP
    bus_start();
    write_byte({7'h11, 1'b0}, a);
    chk(a, "R1 address acknowledge", 64'(a), 64'd1);
    write_byte(8'h84, a);
    chk(a, "R3 pointer byte acknowledge", 64'(a), 64'd1);
    mptr = 7'h04; minc = 1'b1;
    bus_start();
    write_byte({7'h11, 1'b1}, a);
    chk(a, "R2 repeated start accepted", 64'(a), 64'd1);
    for (int i = 0; i < 3; i++) begin
      read_byte(d, i < 2);
      chk(d == exp_rd(mptr), "R6 read after repeated start", 64'(d), 64'(exp_rd(mptr)));
      mptr = mptr + 7'd1;
    end
    hold(2);
    chk(sda_oe == 1'b0, "R7 line released after NACK", 64'(sda_oe), 64'd0);
    bus_stop();

    // R5 R6 fixed-pointer read
    wr_txn(7'h11, 8'h01, 0, 1'b1);
    rd_txn(7'h11, 2);

    // R11 out of range pointer
    wbuf[0] = 8'h77;
    wr_txn(7'h11, 8'h0A, 1, 1'b1);
    chk(cfg == mdl_flat(), "R11 out-of-range write dropped", 64'(cfg), 64'(mdl_flat()));
    rd_txn(7'h11, 1);

    // R2 STOP in the middle of a data byte
    bus_start();
    write_byte({7'h11, 1'b0}, a);
    write_byte(8'h03, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk(cfg == mdl_flat(), "R2 aborted byte writes nothing", 64'(cfg), 64'(mdl_flat()));
    mptr = 7'h03; minc = 1'b0;

    // R1 wrong upper address bits
    wbuf[0] = 8'h99;
    wr_txn(7'h31, 8'h00, 1, 1'b0);
    chk(cfg == mdl_flat(), "R1 wrong upper bits ignored", 64'(cfg), 64'(mdl_flat()));

    // constrained random traffic
    for (int it = 0; it < 16; it++) begin
      n  = 1 + int'($urandom_range(2, 0));
      pb = {1'($urandom), 4'd0, 3'($urandom)};
      for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
      wr_txn(7'h11, pb, n, 1'b1);
      chk(cfg == mdl_flat(), "R4 R5 random write", 64'(cfg), 64'(mdl_flat()));
      pb = {1'($urandom), 4'd0, 3'($urandom)};
      wr_txn(7'h11, pb, 0, 1'b1);
      rd_txn(7'h11, 1 + int'($urandom_range(2, 0)));
    end

    // R9 strap falls: mode latched, bus ignored
    strap = 1'b0;
    hold(10);
    chk(spi_sel == 1'b1, "R9 falling strap latches mode", 64'(spi_sel), 64'd1);
    wbuf[0] = 8'hEE;
    wr_txn(7'h10, 8'h00, 1, 1'b0);
    chk(cfg == mdl_flat(), "R9 no writes once latched", 64'(cfg), 64'(mdl_flat()));
    strap = 1'b1;
    hold(10);
    chk(spi_sel == 1'b1, "R9 latch holds", 64'(spi_sel), 64'd1);

    chk(oe_viol == 0, "R8 output moves only with SCL low", 64'(oe_viol), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule